// File: doc/BRIEF.md
# Mobile DDR SDRAM Power-Up Initialization Sequencer

This block walks a mobile DDR SDRAM from power-up to the point where it accepts ordinary traffic. After reset it raises the clock enable and then issues only no-operation cycles until power and clock have had time to settle. It then closes every bank, runs a configurable number of auto-refresh cycles, and writes both the standard mode register and the extended mode register from values fixed by parameters. All waits are counted in controller clock cycles.

The sequencer drives the command, bank and address pins by itself until it raises its done flag. From then on it holds a no-operation pattern, and the memory controller takes the pins over. The extended register write selects how much of the array stays refreshed in self-refresh: all of it, half or a quarter. A parameter decides which of the two registers is written first.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted, `cke_o` is 0, `cmd_o` is the no-operation code 4'b0111 (bit order {cs_n, ras_n, cas_n, we_n}), `ba_o` and `addr_o` are 0 and `init_done_o` is 0. `cke_o` is 1 from the first clock edge after reset release.
- R2: The only code on `cmd_o` before precharge-all is no-operation. Precharge-all (4'b0010, `addr_o` = 1 at bit 10 and 0 elsewhere, `ba_o` = 2'b00) first appears after clock edge T_STABLE_CYC counted from reset release. The default of 25000 cycles is 200 µs at 125 MHz. Every command follows the expiry of the preceding wait.
- R3: N_REFRESH auto-refresh commands (4'b0111 is never used for them; their code is 4'b0001, with `ba_o` and `addr_o` 0) follow. The first comes T_RP_CYC cycles after precharge-all, and each later one comes T_RFC_CYC cycles after the previous refresh.
- R4: The first register write (code 4'b0000) comes T_RFC_CYC cycles after the last refresh. The second comes T_MRD_CYC cycles after the first. When EXT_FIRST is 0 the standard register is written first; when it is 1 the extended register is written first.
- R5: The standard register write uses `ba_o` = 2'b00. Its `addr_o[2:0]` carries the burst length code (2→001, 4→010, 8→011, 16→100), `addr_o[3]` is 1 for interleaved bursts and 0 for sequential bursts, and `addr_o[6:4]` carries the CAS latency (2→010, 3→011). All higher address bits are 0.
- R6: The extended register write uses `ba_o` = 2'b10. Its `addr_o[2:0]` carries the refreshed-array code (full 000, half 001, quarter 010), and all higher address bits are 0.
- R7: `init_done_o` rises exactly T_MRD_CYC cycles after the second register write, with only no-operation in between.
- R8: Once `init_done_o` is 1 it stays 1, and `cmd_o` stays no-operation with `ba_o` and `addr_o` at 0, until the next reset.
- R9: A reset at any point in the sequence restarts the whole sequence from the settling wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} command code |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Row/mode address bus |
| init_done_o | output | 1 | Initialization complete; the pins are released |

## Verification
Every output is registered, so a command decided on the clock edge where the previous wait expires becomes visible in the cycle after that edge. As a result, the spacing between two commands equals the wait parameter exactly. The bench counts clock edges from reset release and samples at the falling edge. For each expected command it records the edge count at which the command appears and compares that distance with the parameter. This covers precharge-all at T_STABLE_CYC, the refresh and register spacings, and the done flag at T_MRD_CYC after the last register write. Immediately after each walk, the bench watches the idle pins for a stretch of cycles. A reset applied partway through the sequence must produce the full timeline again.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_PREALL,
    OP_REFRESH,
    OP_MODE,
    OP_EXTMODE
  } op_e;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  localparam logic [1:0] BANK_MODE = 2'b00;
  localparam logic [1:0] BANK_EXT  = 2'b10;

  function automatic logic [2:0] burst_code(input int len);
    case (len)
      2:       return 3'b001;
      8:       return 3'b011;
      16:      return 3'b100;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [6:0] mode_word(input int len, input bit interleave, input int cas);
    logic [2:0] lat;
    lat = (cas == 2) ? 3'b010 : 3'b011;
    return {lat, interleave, burst_code(len)};
  endfunction

  function automatic logic [2:0] pasr_code(input int fraction);
    case (fraction)
      2:       return 3'b001;
      4:       return 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
  parameter int W         = 16,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= W'(RESET_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_pwrup_cmd_drive.sv
module sdram_pwrup_cmd_drive
  import sdram_pwrup_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] MODE_ADDR = '0,
  parameter logic [ADDR_W-1:0] EXT_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  output logic [3:0]        cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
    end else begin
      case (op)
        OP_PREALL:  begin cmd <= CMD_PRE; ba <= '0;        addr <= ALL_BANKS; end
        OP_REFRESH: begin cmd <= CMD_REF; ba <= '0;        addr <= '0;        end
        OP_MODE:    begin cmd <= CMD_MRS; ba <= BANK_MODE; addr <= MODE_ADDR; end
        OP_EXTMODE: begin cmd <= CMD_MRS; ba <= BANK_EXT;  addr <= EXT_ADDR;  end
        default:    begin cmd <= CMD_NOP; ba <= '0;        addr <= '0;        end
      endcase
    end
  end
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_pwrup_pkg::*;
#(
  parameter int ADDR_W           = 12,
  parameter int T_STABLE_CYC     = 25000,
  parameter int T_RP_CYC         = 3,
  parameter int T_RFC_CYC        = 10,
  parameter int T_MRD_CYC        = 2,
  parameter int N_REFRESH        = 2,
  parameter int BURST_LEN        = 4,
  parameter bit BURST_INTERLEAVE = 1'b0,
  parameter int CAS_LAT          = 3,
  parameter int ARRAY_FRACTION   = 1,
  parameter bit EXT_FIRST        = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke_o,
  output logic [3:0]        cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);
  localparam int CNT_W = $clog2(max4(T_STABLE_CYC, T_RP_CYC, T_RFC_CYC, T_MRD_CYC) + 1);
  localparam int REF_W = $clog2(N_REFRESH + 1);
  localparam logic [ADDR_W-1:0] MODE_ADDR =
    ADDR_W'(mode_word(BURST_LEN, BURST_INTERLEAVE, CAS_LAT));
  localparam logic [ADDR_W-1:0] EXT_ADDR = ADDR_W'(pasr_code(ARRAY_FRACTION));

  typedef enum logic [2:0] {
    PH_SETTLE, PH_REFRESH, PH_REG_A, PH_REG_B, PH_FINISH, PH_IDLE
  } phase_e;

  phase_e             ph_q, ph_d;
  logic [REF_W-1:0]   refs_q, refs_d;
  logic               done_q, cke_q;
  op_e                op;
  op_e                first_op, second_op;
  logic               load;
  logic [CNT_W-1:0]   load_val;

  // internal events brought out for the checker
  logic               wait_over;
  logic               done_set;

  generate
    if (EXT_FIRST) begin : g_ext_first
      assign first_op  = OP_EXTMODE;
      assign second_op = OP_MODE;
    end else begin : g_mode_first
      assign first_op  = OP_MODE;
      assign second_op = OP_EXTMODE;
    end
  endgenerate

  sdram_pwrup_timer #(
    .W         (CNT_W),
    .RESET_VAL (T_STABLE_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .zero     (wait_over)
  );

  always_comb begin
    ph_d     = ph_q;
    refs_d   = refs_q;
    op       = OP_NOP;
    load     = 1'b0;
    load_val = '0;
    done_set = 1'b0;
    if (wait_over) begin
      case (ph_q)
        PH_SETTLE: begin
          op       = OP_PREALL;
          load     = 1'b1;
          load_val = CNT_W'(T_RP_CYC - 1);
          ph_d     = PH_REFRESH;
        end
        PH_REFRESH: begin
          op       = OP_REFRESH;
          load     = 1'b1;
          load_val = CNT_W'(T_RFC_CYC - 1);
          if (refs_q == REF_W'(N_REFRESH - 1)) ph_d = PH_REG_A;
          else refs_d = refs_q + 1'b1;
        end
        PH_REG_A: begin
          op       = first_op;
          load     = 1'b1;
          load_val = CNT_W'(T_MRD_CYC - 1);
          ph_d     = PH_REG_B;
        end
        PH_REG_B: begin
          op       = second_op;
          load     = 1'b1;
          load_val = CNT_W'(T_MRD_CYC - 1);
          ph_d     = PH_FINISH;
        end
        PH_FINISH: begin
          done_set = 1'b1;
          ph_d     = PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_SETTLE;
      refs_q <= '0;
      done_q <= 1'b0;
      cke_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      refs_q <= refs_d;
      cke_q  <= 1'b1;
      if (done_set) done_q <= 1'b1;
    end
  end

  sdram_pwrup_cmd_drive #(
    .ADDR_W    (ADDR_W),
    .MODE_ADDR (MODE_ADDR),
    .EXT_ADDR  (EXT_ADDR)
  ) u_drive (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .cmd   (cmd_o),
    .ba    (ba_o),
    .addr  (addr_o)
  );

  assign cke_o       = cke_q;
  assign init_done_o = done_q;
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk
  import sdram_pwrup_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int T_MRD_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_o,
  input logic [3:0]        cmd_o,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              init_done_o,
  input logic              wait_over
);
  logic [31:0] gap_q;
  logic        last_mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q       <= '0;
      last_mode_q <= 1'b0;
    end else if (cmd_o != CMD_NOP) begin
      gap_q       <= 32'd1;
      last_mode_q <= (cmd_o == CMD_MRS);
    end else begin
      gap_q <= gap_q + 32'd1;
    end
  end

  assert_cke_on_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP) |-> cke_o);

  assert_preall_a10_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE) |-> (addr_o[10] && ba_o == 2'b00));

  assert_cmd_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP) |-> $past(wait_over));

  assert_mode_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS) |-> (ba_o == BANK_MODE || ba_o == BANK_EXT));

  assert_mrd_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != CMD_NOP || $rose(init_done_o)) && last_mode_q) |-> (gap_q == 32'(T_MRD_CYC)));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);

  assert_bus_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |-> (cmd_o == CMD_NOP && ba_o == 2'b00 && addr_o == '0));
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .ADDR_W    (ADDR_W),
  .T_MRD_CYC (T_MRD_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke_o       (cke_o),
  .cmd_o       (cmd_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .init_done_o (init_done_o),
  .wait_over   (wait_over)
);

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;

  logic        a_cke, a_done, b_cke, b_done;
  logic [3:0]  a_cmd, b_cmd;
  logic [1:0]  a_ba, b_ba;
  logic [11:0] a_addr, b_addr;

  // instance A: defaults (BL4, sequential, CL3, full array, standard first)
  sdram_pwrup_seq u_sdram_pwrup_seq (
    .clk (clk), .rst_n (rst_n), .cke_o (a_cke), .cmd_o (a_cmd),
    .ba_o (a_ba), .addr_o (a_addr), .init_done_o (a_done)
  );

  // instance B: short waits, BL8, interleaved, CL2, quarter array, extended first
  sdram_pwrup_seq #(
    .T_STABLE_CYC (40), .T_RP_CYC (2), .T_RFC_CYC (4), .T_MRD_CYC (3),
    .BURST_LEN (8), .BURST_INTERLEAVE (1'b1), .CAS_LAT (2),
    .ARRAY_FRACTION (4), .EXT_FIRST (1'b1)
  ) u_sdram_pwrup_seq_b (
    .clk (clk), .rst_n (rst_n), .cke_o (b_cke), .cmd_o (b_cmd),
    .ba_o (b_ba), .addr_o (b_addr), .init_done_o (b_done)
  );

  localparam logic [3:0] NOP = 4'b0111;

  // {cmd, ba, addr, gap in cycles}; cmd NOP marks the done flag
  localparam int NE = 12;
  localparam logic [33:0] TBL [NE] = '{
    {4'b0010, 2'b00, 12'h400, 16'd40},
    {4'b0001, 2'b00, 12'h000, 16'd2},
    {4'b0001, 2'b00, 12'h000, 16'd4},
    {4'b0000, 2'b10, 12'h002, 16'd4},
    {4'b0000, 2'b00, 12'h02B, 16'd3},
    {NOP,     2'b00, 12'h000, 16'd3},
    {4'b0010, 2'b00, 12'h400, 16'd25000},
    {4'b0001, 2'b00, 12'h000, 16'd3},
    {4'b0001, 2'b00, 12'h000, 16'd10},
    {4'b0000, 2'b00, 12'h032, 16'd10},
    {4'b0000, 2'b10, 12'h000, 16'd2},
    {NOP,     2'b00, 12'h000, 16'd2}
  };

  int n_vec = 0;
  int n_bad = 0;
  logic sel = 1'b0;

  logic        s_cke, s_done;
  logic [3:0]  s_cmd;
  logic [1:0]  s_ba;
  logic [11:0] s_addr;
  always_comb begin
    s_cke  = sel ? b_cke  : a_cke;
    s_done = sel ? b_done : a_done;
    s_cmd  = sel ? b_cmd  : a_cmd;
    s_ba   = sel ? b_ba   : a_ba;
    s_addr = sel ? b_addr : a_addr;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state A", {a_cke, a_done, a_cmd, a_ba, a_addr},
          {1'b0, 1'b0, NOP, 2'b00, 12'h000});
    check("R1 reset state B", {b_cke, b_done, b_cmd, b_ba, b_addr},
          {1'b0, 1'b0, NOP, 2'b00, 12'h000});
    rst_n = 1'b1;
  endtask

  // walks table entries [first, first+count) right after reset release
  task automatic walk(input int first, input int count);
    int n = 0;
    int prev = 0;
    for (int i = first; i < first + count; i++) begin
      logic [33:0] e;
      bit found;
      e = TBL[i];
      found = 1'b0;
      while (!found && (n - prev) < 30000) begin
        @(negedge clk);
        n++;
        if (e[33:30] == NOP) found = s_done;
        else found = (s_cmd != NOP) || s_done;
      end
      if (e[33:30] == NOP)
        check("R7 done flag delay", {s_done, s_cmd, 16'(n - prev)}, {1'b1, NOP, e[15:0]});
      else if (i == first)
        check("R2 precharge-all and R1 cke", {s_cke, s_cmd, s_ba, s_addr, 16'(n - prev)},
              {1'b1, e});
      else if (e[33:30] == 4'b0001)
        check("R3 refresh", {s_cmd, s_ba, s_addr, 16'(n - prev)}, e);
      else
        check("R4 R5 R6 register write", {s_cmd, s_ba, s_addr, 16'(n - prev)}, e);
      prev = n;
    end
  endtask

  task automatic idle_watch(input int cycles);
    bit ok = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (!(s_done && s_cmd == NOP && s_ba == 2'b00 && s_addr == 12'h000)) ok = 1'b0;
    end
    check("R8 pins stay released", {63'd0, ok}, 64'd1);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    sel = 1'b1;
    apply_reset();
    walk(0, 6);
    idle_watch(40);
    // R9: interrupt after the refreshes, then the full timeline must repeat
    apply_reset();
    walk(0, 3);
    apply_reset();
    walk(0, 6);
    sel = 1'b0;
    apply_reset();
    walk(6, 6);
    idle_watch(40);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule